// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller

This block is a general-purpose I/O peripheral that sits on a simple register bus with separate read and write strobes, a word address and a data word. The bus word width equals the number of pins and is a build parameter of 8, 16, 32 or 64. Software drives pins through an output latch and chooses which pins are outputs through one direction register. It reads pin levels back through a two-flop synchroniser. The pad ring receives an output-value vector and an output-enable vector for its tristate buffers.

Build parameters select several behaviours. Set and clear registers can sit beside the data register as a write-one pair, or a single set register can hold the whole output value, or neither is built. A 1 in the direction register can mean "output" or "input". The bus view can number the pins in reverse bit order. For 16- and 32-bit widths, the bus view can also swap the bytes of every word. Word addresses are fixed: data at 0, set at 1, clear at 2, direction at 3. Addresses 4 to 7 are unimplemented.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: After reset the output latch is 0 and every pin is an input, so `pad_out` and `pad_oe` are all zeros. The direction register reads 0 when a 1 means output, and all ones when a 1 means input.
- R2: A write to address 0 replaces the whole output latch, and `pad_out` shows it after the write edge. Without a write, `pad_out` and `pad_oe` do not change.
- R3: A read returns its word on `bus_rdata` after the edge that samples the strobe, and that word holds until the next read. A read of address 0 returns pin levels through two synchroniser flops. A pin change made in the cycle of a read strobe is seen only by a read strobed two cycles later.
- R4: With the set/clear pair built, a write to address 1 sets each latch bit whose written bit is 1 and leaves bits written 0 untouched. Address 1 reads 0.
- R5: With the set/clear pair built, a write to address 2 clears each latch bit whose written bit is 1 and leaves bits written 0 untouched. Address 2 reads 0.
- R6: In set-only mode, a write to address 1 replaces the whole latch and a read of address 1 returns the latch. Address 2 then behaves as unimplemented.
- R7: In output-polarity mode, a 1 in direction register bit n (address 3, read back unchanged) drives `pad_oe[n]` high.
- R8: In input-polarity mode, a 1 in direction register bit n makes pin n an input, so `pad_oe[n]` is the inverse of the stored bit.
- R9: With reversed numbering, pin n appears at bus bit W-1-n for writes and reads alike.
- R10: With byte swapping, bus byte k maps to register byte (W/8-1-k). A 16-bit bus write of 0x1200 with reversed numbering drives pins 11 and 14. Byte swapping with W=64 is rejected at elaboration.
- R11: Reads of an unimplemented address (4 to 7, or an absent set or clear register) return 0, and writes to one change neither pad vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | W | Write data in bus order |
| bus_rdata | output | W | Registered read data in bus order |
| pin_in | input | W | Pad input levels, asynchronous |
| pad_out | output | W | Output value per pin |
| pad_oe | output | W | Output enable per pin, 1 drives the pad |

## Verification
A register write shows on `pad_out` or `pad_oe` after the single edge that samples the strobe, so the bench checks the pads at the falling edge after that edge. Read data is due one edge after the read strobe. A scoreboard queues the expected word when the strobe goes out, and a monitor pops it at the following falling edge. Pin levels pass through two more flops, so the bench issues three back-to-back reads across a pin change and expects old, old, new.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA = 3'd0,
        RA_SET  = 3'd1,
        RA_CLR  = 3'd2,
        RA_DIR  = 3'd3
    } addr_e;

    typedef enum logic [1:0] {
        LATCH_PLAIN   = 2'd0,
        LATCH_SET_ONLY = 2'd1,
        LATCH_SET_CLR = 2'd2
    } latch_mode_e;

    typedef enum logic {
        DIR_ONE_IS_OUT = 1'b0,
        DIR_ONE_IS_IN  = 1'b1
    } dir_pol_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_e addr;
    } bus_cmd_t;

    function automatic bit width_ok(int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
    parameter int W         = 32,
    parameter bit BIT_REV   = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam int NB = W / 8;

    logic [W-1:0] stage;

    generate
        if (BIT_REV) begin : g_rev
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign stage[i] = a[W-1-i];
            end
        end else begin : g_norev
            assign stage = a;
        end

        if (BYTE_SWAP) begin : g_swap
            for (genvar b = 0; b < NB; b++) begin : g_byte
                assign y[8*b +: 8] = stage[8*(NB-1-b) +: 8];
            end
        end else begin : g_noswap
            assign y = stage;
        end
    endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int          W          = 32,
    parameter latch_mode_e LATCH_MODE = LATCH_SET_CLR,
    parameter dir_pol_e    DIR_POL    = DIR_ONE_IS_OUT
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_cmd_t     cmd,
    input  logic [W-1:0] wdata_p,
    input  logic [W-1:0] pins_s,
    output logic [W-1:0] rdata_p,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    localparam logic [W-1:0] DIR_RST = (DIR_POL == DIR_ONE_IS_IN) ? '1 : '0;
    localparam bit HAS_PAIR = (LATCH_MODE == LATCH_SET_CLR);
    localparam bit SET_FULL = (LATCH_MODE == LATCH_SET_ONLY);

    logic [W-1:0] rsel;

    always_comb begin
        unique case (cmd.addr)
            RA_DATA: rsel = pins_s;
            RA_SET:  rsel = SET_FULL ? latch_q : '0;
            RA_DIR:  rsel = dir_q;
            default: rsel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= DIR_RST;
        end else if (cmd.wr) begin
            unique case (cmd.addr)
                RA_DATA: latch_q <= wdata_p;
                RA_SET: begin
                    if (SET_FULL)      latch_q <= wdata_p;
                    else if (HAS_PAIR) latch_q <= latch_q | wdata_p;
                end
                RA_CLR: begin
                    if (HAS_PAIR) latch_q <= latch_q & ~wdata_p;
                end
                RA_DIR:  dir_q <= wdata_p;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_p <= '0;
        else if (cmd.rd) rdata_p <= rsel;
    end
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int          W          = 32,
    parameter latch_mode_e LATCH_MODE = LATCH_SET_CLR,
    parameter dir_pol_e    DIR_POL    = DIR_ONE_IS_OUT,
    parameter bit          BIT_REV    = 1'b0,
    parameter bit          BYTE_SWAP  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    generate
        if (!width_ok(W)) begin : g_bad_width
            $error("mmio_gpio_ctrl: W must be 8, 16, 32 or 64");
        end
        if (BYTE_SWAP && (W == 64)) begin : g_bad_swap
            $error("mmio_gpio_ctrl: byte swapping is not available at W=64");
        end
    endgenerate

    bus_cmd_t     cmd;
    logic [W-1:0] wdata_p;
    logic [W-1:0] rdata_p;
    logic [W-1:0] pins_s;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;

    assign cmd.wr   = bus_wr;
    assign cmd.rd   = bus_rd;
    assign cmd.addr = addr_e'(bus_addr);

    gpio_lane_map #(.W(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_map_wr (
        .a (bus_wdata),
        .y (wdata_p)
    );

    gpio_sync2 #(.W(W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_s)
    );

    gpio_regfile #(.W(W), .LATCH_MODE(LATCH_MODE), .DIR_POL(DIR_POL)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata_p (wdata_p),
        .pins_s  (pins_s),
        .rdata_p (rdata_p),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_lane_map #(.W(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_map_rd (
        .a (rdata_p),
        .y (bus_rdata)
    );

    assign pad_out = latch_q;

    generate
        if (DIR_POL == DIR_ONE_IS_IN) begin : g_oe_inv
            assign pad_oe = ~dir_q;
        end else begin : g_oe_dir
            assign pad_oe = dir_q;
        end
    endgenerate
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int          W          = 32,
    parameter latch_mode_e LATCH_MODE = LATCH_SET_CLR
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe
);
    localparam bit PAIR = (LATCH_MODE == LATCH_SET_CLR);

    // R1: first cycle out of reset shows the idle pad state
    p_reset_pads_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_out == '0) && (pad_oe == '0));

    // R2: no write, no pad change
    p_hold_pads_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pad_out) && $stable(pad_oe));

    // R3: read data only moves on a read strobe
    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R4: a set write never drops a driven bit
    p_set_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (PAIR && bus_wr && bus_addr == 3'd1) |=>
        ((pad_out & $past(pad_out)) == $past(pad_out)));

    // R5: a clear write never raises a bit
    p_clr_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (PAIR && bus_wr && bus_addr == 3'd2) |=>
        ((pad_out & ~$past(pad_out)) == '0));

    // R11: writes to the upper address half change nothing
    p_unimpl_wr_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[2]) |=> $stable(pad_out) && $stable(pad_oe));

    // R11: reads of the upper address half return zero
    p_unimpl_rd_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[2]) |=> (bus_rdata == '0));
endmodule

bind mmio_gpio_ctrl gpio_ctrl_chk #(.W(W), .LATCH_MODE(LATCH_MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/mmio_gpio_ctrl_bench.sv
module mmio_gpio_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 32;
    localparam int AW = 16;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // main instance: 32 bits, set/clear pair, 1 = output
    logic          m_wr = 1'b0, m_rd = 1'b0, m_rd_d = 1'b0;
    logic [2:0]    m_addr = '0;
    logic [MW-1:0] m_wdata = '0, m_pin = '0;
    logic [MW-1:0] m_rdata, m_out, m_oe;

    mmio_gpio_ctrl #(.W(MW)) u_mmio_gpio_ctrl (
        .clk(clk), .rst(rst), .bus_wr(m_wr), .bus_rd(m_rd), .bus_addr(m_addr),
        .bus_wdata(m_wdata), .bus_rdata(m_rdata), .pin_in(m_pin),
        .pad_out(m_out), .pad_oe(m_oe)
    );

    // second instance: 16 bits, set-only, 1 = input, reversed bits, swapped bytes
    logic          a_wr = 1'b0, a_rd = 1'b0, a_rd_d = 1'b0;
    logic [2:0]    a_addr = '0;
    logic [AW-1:0] a_wdata = '0, a_pin = '0;
    logic [AW-1:0] a_rdata, a_out, a_oe;

    mmio_gpio_ctrl #(
        .W(AW), .LATCH_MODE(gpio_pkg::LATCH_SET_ONLY), .DIR_POL(gpio_pkg::DIR_ONE_IS_IN),
        .BIT_REV(1'b1), .BYTE_SWAP(1'b1)
    ) u_mmio_gpio_ctrl_alt (
        .clk(clk), .rst(rst), .bus_wr(a_wr), .bus_rd(a_rd), .bus_addr(a_addr),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata), .pin_in(a_pin),
        .pad_out(a_out), .pad_oe(a_oe)
    );

    item_t m_q[$];
    item_t a_q[$];
    item_t m_it, a_it;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // bench model of the alt mapping: byte swap then reverse, 16 bits
    function automatic logic [AW-1:0] alt_map(input logic [AW-1:0] v);
        logic [AW-1:0] s = {v[7:0], v[15:8]};
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = s[AW-1-i];
        return r;
    endfunction

    always @(posedge clk) begin
        m_rd_d <= m_rd;
        a_rd_d <= a_rd;
    end

    // monitor: compare read results the cycle after each strobe
    always @(negedge clk) begin
        if (m_rd_d) begin
            if (m_q.size() == 0) chk("R3 unexpected main read", 64'd1, 64'd0);
            else begin
                m_it = m_q.pop_front();
                chk(m_it.tag, {32'd0, m_rdata}, m_it.exp);
            end
        end
        if (a_rd_d) begin
            if (a_q.size() == 0) chk("R3 unexpected alt read", 64'd1, 64'd0);
            else begin
                a_it = a_q.pop_front();
                chk(a_it.tag, {48'd0, a_rdata}, a_it.exp);
            end
        end
    end

    task automatic m_write(input logic [2:0] ad, input logic [MW-1:0] d);
        m_wr = 1'b1; m_addr = ad; m_wdata = d;
        @(negedge clk);
        m_wr = 1'b0;
    endtask

    task automatic m_read(input logic [2:0] ad, input logic [MW-1:0] e, input string tag);
        item_t it;
        it.exp = {32'd0, e}; it.tag = tag;
        m_q.push_back(it);
        m_rd = 1'b1; m_addr = ad;
        @(negedge clk);
        m_rd = 1'b0;
    endtask

    task automatic a_write(input logic [2:0] ad, input logic [AW-1:0] d);
        a_wr = 1'b1; a_addr = ad; a_wdata = d;
        @(negedge clk);
        a_wr = 1'b0;
    endtask

    task automatic a_read(input logic [2:0] ad, input logic [AW-1:0] e, input string tag);
        item_t it;
        it.exp = {48'd0, e}; it.tag = tag;
        a_q.push_back(it);
        a_rd = 1'b1; a_addr = ad;
        @(negedge clk);
        a_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 main pad_out", {32'd0, m_out}, 64'd0);
        chk("R1 main pad_oe", {32'd0, m_oe}, 64'd0);
        chk("R1 alt pad_oe", {48'd0, a_oe}, 64'd0);
        m_read(3'd3, 32'h0, "R1 main dir reset");
        a_read(3'd3, 16'hFFFF, "R1 alt dir reset all ones");

        // R2 data write
        m_write(3'd0, 32'hA5A5_0F0F);
        chk("R2 data write", {32'd0, m_out}, 64'hA5A5_0F0F);

        // R4 set
        m_write(3'd1, 32'h0000_00F0);
        chk("R4 set ones", {32'd0, m_out}, 64'hA5A5_0FFF);
        m_write(3'd1, 32'h0);
        chk("R4 set zeros no effect", {32'd0, m_out}, 64'hA5A5_0FFF);
        m_read(3'd1, 32'h0, "R4 set reads zero");

        // R5 clear
        m_write(3'd2, 32'h0000_000F);
        chk("R5 clear low nibble", {32'd0, m_out}, 64'hA5A5_0FF0);
        m_write(3'd2, 32'hA000_0000);
        chk("R5 clear top bits", {32'd0, m_out}, 64'h05A5_0FF0);
        m_read(3'd2, 32'h0, "R5 clear reads zero");

        // R7 direction, 1 = output
        m_write(3'd3, 32'h0000_FFFF);
        chk("R7 oe follows dir", {32'd0, m_oe}, 64'h0000_FFFF);
        m_read(3'd3, 32'h0000_FFFF, "R7 dir readback");

        // R3 synchroniser latency: old, old, new
        m_pin = 32'hCAFE_F00D;
        m_read(3'd0, 32'h0, "R3 pin read edge 1 old");
        m_read(3'd0, 32'h0, "R3 pin read edge 2 old");
        m_read(3'd0, 32'hCAFE_F00D, "R3 pin read edge 3 new");

        // R11 unimplemented
        m_write(3'd5, 32'hFFFF_FFFF);
        chk("R11 unimpl write pad_out", {32'd0, m_out}, 64'h05A5_0FF0);
        chk("R11 unimpl write pad_oe", {32'd0, m_oe}, 64'h0000_FFFF);
        m_read(3'd6, 32'h0, "R11 unimpl read 6");
        m_read(3'd4, 32'h0, "R11 unimpl read 4");

        m_write(3'd0, 32'h0);
        chk("R2 data write zero", {32'd0, m_out}, 64'd0);

        // R9/R10 mapping on alt instance
        a_write(3'd0, 16'h0001);
        chk("R9 R10 bus bit0 to pin7", {48'd0, a_out}, 64'h0080);
        a_write(3'd0, 16'h1200);
        chk("R10 swapped word to pins 11 and 14", {48'd0, a_out}, 64'h4800);

        // R6 set-only
        a_write(3'd1, 16'h0002);
        chk("R6 set replaces latch", {48'd0, a_out}, {48'd0, alt_map(16'h0002)});
        a_read(3'd1, 16'h0002, "R6 set reads latch");

        // R11 absent clear register
        a_write(3'd2, 16'hFFFF);
        chk("R11 absent clear ignored", {48'd0, a_out}, 64'h0040);
        a_read(3'd2, 16'h0, "R11 absent clear reads zero");

        // R8 direction, 1 = input
        a_write(3'd3, 16'hFFFE);
        chk("R8 oe inverse of dir", {48'd0, a_oe}, 64'h0080);
        a_read(3'd3, 16'hFFFE, "R8 dir readback");

        // R9 pin read through mapping
        a_pin = 16'h0001;
        repeat (3) @(negedge clk);
        a_read(3'd0, 16'h0080, "R9 pin0 read at bus bit7");

        repeat (2) @(negedge clk);
        chk("R3 scoreboard drained", 64'(m_q.size() + a_q.size()), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule